// File: doc/BRIEF.md
# Routed Level Interrupt Combiner

This block gathers thirty-two level-sensitive interrupt request lines and folds them onto two processor interrupt pins. Software reaches it over a simple 32-bit register port addressed by byte offset. Writes take effect at the clock edge. Read data is returned combinationally for the address currently presented. The enable state is never rewritten as a whole word. One register sets enable bits and another clears them, each acting only on the bits written as one. This lets independent drivers mask their own sources without a read-modify-write race.

A routing word picks the output pin for each source. Two status registers, one per pin, show which routed sources are both active and enabled. A raw register shows the request lines exactly as they arrive. The top bit of the enable word also acts as a master gate: neither pin can assert while it is clear.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, every enable bit (bit 31 included) and every routing bit is zero, both `irq_o` bits are low, and every register reads zero while the inputs are low.
- R2: A write to offset 0x34 sets each enable bit whose written bit is 1 and leaves every other enable bit as it was.
- R3: A write to offset 0x38 clears each enable bit whose written bit is 1 and leaves every other enable bit as it was; writing all ones clears the whole enable word.
- R4: While enable bit 31 is 0, both `irq_o` bits are 0 whatever the sources, enables and routing are.
- R5: Routing bit n = 0 sends source n to `irq_o[0]` and = 1 sends it to `irq_o[1]`; the routing word is written and read back at offset 0x20.
- R6: Offset 0x00 reads `src_i & enable & ~route` and offset 0x04 reads `src_i & enable & route`, neither gated by bit 31.
- R7: Status bits follow the input levels; writes to 0x00, 0x04 and 0x30 change no state.
- R8: Offset 0x30 reads `src_i` directly, unaffected by enable or routing.
- R9: Offset 0x34 reads back the enable word, offset 0x38 reads zero, and any other offset (unaligned ones included) reads zero and ignores writes.
- R10: `irq_o[k]` is 1 exactly when bit 31 is set and the status word of output k is nonzero; it follows `src_i` in the same cycle, and a register write shows its effect from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Level interrupt request lines |
| we_i | input | 1 | Write strobe for the register port |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 2 | Combined interrupt outputs |

## Verification
Two things often happen in the same cycle: a source line changes while software writes the enable-set, enable-clear or routing register. The bench drives a new source pattern in the same cycle as each write, often as a burst of unrelated accesses. It checks that `irq_o` reacts at once to the new levels, still using the old enable and routing state. It then checks that the write shows up only from the next cycle. A behavioural model in the bench gives the expected pins and read data for every cycle, and these are compared in each cycle. Runs with bit 31 cleared while sources stay active judge the master gate separately from the per-source masks.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 8;
  localparam int N_OUT    = 2;
  localparam int GATE_BIT = DATA_W - 1;

  localparam logic [ADDR_W-1:0] OFS_STAT0 = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT1 = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_ROUTE = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_ENSET = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_ENCLR = 8'h38;

  typedef enum logic [2:0] {
    SEL_STAT0, SEL_STAT1, SEL_ROUTE, SEL_RAW, SEL_ENSET, SEL_ENCLR, SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_STAT0: return SEL_STAT0;
      OFS_STAT1: return SEL_STAT1;
      OFS_ROUTE: return SEL_ROUTE;
      OFS_RAW:   return SEL_RAW;
      OFS_ENSET: return SEL_ENSET;
      OFS_ENCLR: return SEL_ENCLR;
      default:   return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_ctrl_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  reg_sel_e     sel_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] route_o
);
  logic [W-1:0] en_q, route_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      route_q <= '0;
    end else if (we_i) begin
      case (sel_i)
        SEL_ENSET: en_q    <= en_q | wdata_i;
        SEL_ENCLR: en_q    <= en_q & ~wdata_i;
        SEL_ROUTE: route_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign en_o    = en_q;
  assign route_o = route_q;

  // R2
  enset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_ENSET) |=>
      ((en_q & $past(wdata_i)) == $past(wdata_i)) &&
      ((en_q & ~$past(wdata_i)) == ($past(en_q) & ~$past(wdata_i))));

  // R3
  enclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_ENCLR) |=>
      ((en_q & $past(wdata_i)) == '0) &&
      ((en_q & ~$past(wdata_i)) == ($past(en_q) & ~$past(wdata_i))));

  // R7 R9
  nowrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i || sel_i inside {SEL_STAT0, SEL_STAT1, SEL_RAW, SEL_NONE}) |=>
      $stable(en_q) && $stable(route_q));
endmodule

// File: rtl/irq_ctrl_route.sv
module irq_ctrl_route
  import irq_ctrl_pkg::*;
#(
  parameter int W    = DATA_W,
  parameter int NOUT = N_OUT,
  parameter int GATE = GATE_BIT
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] route_i,
  output logic [W-1:0] status_o [NOUT],
  output logic [NOUT-1:0] irq_o
);
  for (genvar k = 0; k < NOUT; k++) begin : g_out
    logic [W-1:0] pick;
    assign pick        = (k == 0) ? ~route_i : route_i;
    assign status_o[k] = src_i & en_i & pick;
    assign irq_o[k]    = en_i[GATE] & (|status_o[k]);
  end

  // R10
  dual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o[0] && irq_o[1]) |-> ((src_i & en_i) != '0) && (route_i != '0) && (route_i != '1));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] src_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_OUT-1:0]  irq_o
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] en, route;
  logic [DATA_W-1:0] status [N_OUT];

  assign sel = decode(addr_i);

  irq_ctrl_regs #(.W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .sel_i(sel), .wdata_i,
    .en_o(en), .route_o(route)
  );

  irq_ctrl_route #(.W(DATA_W), .NOUT(N_OUT), .GATE(GATE_BIT)) u_route (
    .clk_i, .rst_ni, .src_i, .en_i(en), .route_i(route),
    .status_o(status), .irq_o
  );

  always_comb begin
    case (sel)
      SEL_STAT0: rdata_o = status[0];
      SEL_STAT1: rdata_o = status[1];
      SEL_ROUTE: rdata_o = route;
      SEL_RAW:   rdata_o = src_i;
      SEL_ENSET: rdata_o = en;
      default:   rdata_o = '0;
    endcase
  end

  // R4
  gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en[GATE_BIT] |-> irq_o == '0);

  // R8
  raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_RAW) |-> rdata_o == src_i);
endmodule

// File: tb/irq_ctrl_bench.sv
module irq_ctrl_bench;
  localparam time CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic [31:0] src = '0, wdata = '0, rdata;
  logic        we = 0;
  logic [7:0]  addr = '0;
  logic [1:0]  irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] en_m = '0, ty_m = '0;

  always #(CLK_P/2) clk = ~clk;

  irq_ctrl u_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] exp_rd(input logic [7:0] a, input logic [31:0] s);
    case (a)
      8'h00: return s & en_m & ~ty_m;
      8'h04: return s & en_m & ty_m;
      8'h20: return ty_m;
      8'h30: return s;
      8'h34: return en_m;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [7:0] a);
    case (a)
      8'h00, 8'h04: return "R6";
      8'h20: return "R5";
      8'h30: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic [31:0] s, input string tag = "");
    logic [1:0] ie;
    @(negedge clk);
    we = w; addr = a; wdata = d; src = s;
    #1;
    ie[0] = en_m[31] & |(s & en_m & ~ty_m);
    ie[1] = en_m[31] & |(s & en_m & ty_m);
    chk((tag != "") ? tag : (en_m[31] ? "R10" : "R4"), {30'h0, irq}, {30'h0, ie});
    chk((tag != "") ? tag : rd_tag(a), rdata, exp_rd(a, s));
    @(posedge clk);
    if (w) begin
      case (a)
        8'h34: en_m = en_m | d;
        8'h38: en_m = en_m & ~d;
        8'h20: ty_m = d;
        default: ;
      endcase
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [7:0] amap [8];
    amap = '{8'h00, 8'h04, 8'h20, 8'h30, 8'h34, 8'h38, 8'h10, 8'h35};
    #(CLK_P * 3);
    rst_n = 1;
    // R1 reset state
    step(0, 8'h34, 0, 32'h0, "R1");
    step(0, 8'h20, 0, 32'h0, "R1");
    step(0, 8'h00, 0, 32'hFFFF_FFFF, "R1");
    // R4 sources enabled without gate
    step(1, 8'h34, 32'h0000_00FF, 32'h0000_00FF);
    step(0, 8'h00, 0, 32'h0000_00FF, "R4");
    step(0, 8'h04, 0, 32'h0000_00FF, "R6");
    // R2 set gate, same cycle as source change (R10)
    step(1, 8'h34, 32'h8000_0000, 32'h0000_0001, "R10");
    step(0, 8'h34, 0, 32'h0000_0001, "R2");
    // R5 route to output 1
    step(1, 8'h20, 32'h0000_0001, 32'h0000_0001, "R5");
    step(0, 8'h04, 0, 32'h0000_0001, "R5");
    step(0, 8'h00, 0, 32'h0000_0002, "R5");
    // R7 status and raw ignore writes; status follows level
    step(1, 8'h00, 32'hFFFF_FFFF, 32'h0000_0003, "R7");
    step(1, 8'h30, 32'hFFFF_FFFF, 32'h0, "R7");
    step(1, 8'h04, 32'hFFFF_FFFF, 32'h0000_0003, "R7");
    step(0, 8'h34, 0, 32'h0000_0003, "R7");
    // R8 raw
    step(0, 8'h30, 0, 32'hDEAD_BEEF, "R8");
    // R9 unmapped, unaligned, clear readback
    step(1, 8'h10, 32'hFFFF_FFFF, 32'h1, "R9");
    step(1, 8'h35, 32'hFFFF_FFFF, 32'h1, "R9");
    step(0, 8'h38, 0, 32'h1, "R9");
    step(0, 8'h34, 0, 32'h1, "R9");
    // R3 partial clear then clear all
    step(1, 8'h38, 32'h0000_000F, 32'hFF, "R3");
    step(0, 8'h34, 0, 32'hFF, "R3");
    step(1, 8'h38, 32'hFFFF_FFFF, 32'hFF, "R3");
    step(0, 8'h34, 0, 32'hFF, "R3");
    // R5 all-zero routing
    step(1, 8'h34, 32'hFFFF_FFFF, 32'h0, "R2");
    step(1, 8'h20, 32'h0, 32'h4000_0000, "R5");
    step(0, 8'h00, 0, 32'h4000_0000, "R5");
    // random mix of writes and source changes
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] d, s;
      d = $urandom;
      s = $urandom;
      if ($urandom_range(0, 3) == 0) d = $urandom_range(0, 1) ? 32'h8000_0000 : ~32'h0;
      if ($urandom_range(0, 2) == 0) s = s & (32'h1 << $urandom_range(0, 31));
      step($urandom_range(0, 1), amap[$urandom_range(0, 7)], d, s);
    end
    finish_run();
  end
endmodule